// File: doc/BRIEF.md
# Real-Time Counter Control Register

This block holds a free-running 32-bit real-time counter together with the small register file that controls it. Software reaches the block through a byte-wide register port with an address, write data, a write strobe and combinational read data. The counter advances on a slow tick enable that comes from the real-time clock domain. The control byte lives at address 0x4. It starts and stops the counter. It launches the two transfer commands: set, which loads the counter from a 32-bit holding register, and capture, which copies the counter into that holding register. It also arms an alarm comparator and enables a detector that watches for missing ticks.

The holding register takes addresses 0x0 to 0x3 and the alarm value takes 0x8 to 0xB, both with the least significant byte at the lowest address. A transfer command bit reads back as 1 until its transfer is done and then clears itself. Bit 2 of the control byte has two meanings. A read returns the alarm event flag. A write stores a hidden auto-reset enable. The oscillator enable is only a stored bit, and it drives the `osc_en` output.

Top module: `rtc_ctrl_reg`

## Requirements
- R1: After reset, the control byte reads 0x00 and `alarm_pulse`, `osc_fail` and `osc_en` are all 0.
- R2: Control byte at address 0x4. Bit 7 is the oscillator enable and also drives `osc_en`. Bit 6 enables the missing-tick detector. Bit 4 is run. Bit 3 is alarm enable. These four bits read back as written. The holding register sits at 0x0–0x3 and the alarm value at 0x8–0xB, least significant byte first, and both read back as written.
- R3: While bit 4 is 1, each `rtc_tick` cycle adds 1 to the counter, wrapping modulo 2^32. While bit 4 is 0, the counter keeps its value.
- R4: Writing 1 to bit 1 starts a set. Bit 1 reads 1 in the two cycles that follow the write, and it reads 0 from the third cycle on. On the clock edge that clears bit 1, the counter loads the holding register. A tick in that same cycle is discarded.
- R5: Writing 1 to bit 0 starts a capture with the same timing, using bit 0. On the clock edge that clears bit 0, the holding register takes the counter value from before any tick in that same cycle.
- R6: A tick seen while run and alarm enable are both 1 and the counter equals the alarm value sets the alarm flag. The flag appears on `alarm_pulse` and on bit 2 of the read data. The next tick clears it.
- R7: A write to bit 2 stores the auto-reset enable. Bit 2 still reads the alarm flag, not the stored value. With auto-reset set, the counter loads 0 on the tick that raises the flag. Without auto-reset, the counter keeps counting on that tick.
- R8: Every write to the control byte clears the alarm flag. A write wins over an alarm tick in the same cycle.
- R9: With bit 6 set, `osc_fail` (bit 5) rises after 1024 consecutive clock cycles without a tick, and not before. Any tick restarts that count.
- R10: Writing 0 to bit 5 clears `osc_fail`. Writing 1 to bit 5 leaves it unchanged.
- R11: Reads of any unmapped address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| rtc_tick | input | 1 | One-cycle real-time tick enable |
| alarm_pulse | output | 1 | Alarm event flag, lasts at most one tick period |
| osc_fail | output | 1 | Missing-tick event flag |
| osc_en | output | 1 | Stored oscillator enable |

## Verification
Three pairs of functions can land in the same cycle. A set or capture can complete on a tick. A control write can coincide with an alarm tick. A detector timeout can meet a software clear. For the transfers, the bench raises the tick in exactly the completion cycle. It then reads the counter back through a capture and compares it with the held value (set) or the pre-tick value (capture). For the alarm pair, a flag raised by a match must be gone after the next control write. For the timeout, the detector boundary is probed at 1023 and at 1024 idle cycles counted from a tick.

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg #(
  parameter int ADDR_W     = 4,
  parameter int TW         = 32,
  parameter int CMD_LAT    = 2,
  parameter int MISS_LIMIT = 1024,
  parameter int CTRL_ADDR  = 4,
  parameter int HOLD_BASE  = 0,
  parameter int ALARM_BASE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              rtc_tick,
  output logic              alarm_pulse,
  output logic              osc_fail,
  output logic              osc_en
);
  localparam int NB = TW / 8;
  localparam int CW = $clog2(CMD_LAT + 1);
  localparam int MW = $clog2(MISS_LIMIT + 1);

  logic          osc_en_q, mdet_en_q, fail_q, run_q, alm_en_q, autorst_q, flag_q;
  logic [CW-1:0] set_cnt, cap_cnt;
  logic [TW-1:0] timer_q, hold_q, alarm_q;
  logic [MW-1:0] miss_cnt;

  wire ctrl_wr   = reg_wr && reg_addr == ADDR_W'(CTRL_ADDR);
  wire set_done  = set_cnt == CW'(1);
  wire cap_done  = cap_cnt == CW'(1);
  wire alarm_hit = rtc_tick && run_q && alm_en_q && timer_q == alarm_q;
  wire miss_fire = mdet_en_q && !rtc_tick && miss_cnt == MW'(MISS_LIMIT - 1);

  assign alarm_pulse = flag_q;
  assign osc_fail    = fail_q;
  assign osc_en      = osc_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      osc_en_q  <= 1'b0;
      mdet_en_q <= 1'b0;
      run_q     <= 1'b0;
      alm_en_q  <= 1'b0;
      autorst_q <= 1'b0;
    end else if (ctrl_wr) begin
      osc_en_q  <= reg_wdata[7];
      mdet_en_q <= reg_wdata[6];
      run_q     <= reg_wdata[4];
      alm_en_q  <= reg_wdata[3];
      autorst_q <= reg_wdata[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_cnt <= '0;
      cap_cnt <= '0;
    end else begin
      if (set_cnt != '0)                  set_cnt <= set_cnt - CW'(1);
      else if (ctrl_wr && reg_wdata[1])   set_cnt <= CW'(CMD_LAT);
      if (cap_cnt != '0)                  cap_cnt <= cap_cnt - CW'(1);
      else if (ctrl_wr && reg_wdata[0])   cap_cnt <= CW'(CMD_LAT);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  timer_q <= '0;
    else if (set_done)           timer_q <= hold_q;
    else if (rtc_tick && run_q)  timer_q <= (alarm_hit && autorst_q) ? '0 : timer_q + TW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      alarm_q <= '0;
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (cap_done)
          hold_q[i*8 +: 8] <= timer_q[i*8 +: 8];
        else if (reg_wr && reg_addr == ADDR_W'(HOLD_BASE + i))
          hold_q[i*8 +: 8] <= reg_wdata;
        if (reg_wr && reg_addr == ADDR_W'(ALARM_BASE + i))
          alarm_q[i*8 +: 8] <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (ctrl_wr)  flag_q <= 1'b0;
    else if (rtc_tick) flag_q <= alarm_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_cnt <= '0;
      fail_q   <= 1'b0;
    end else begin
      if (!mdet_en_q || rtc_tick)           miss_cnt <= '0;
      else if (miss_cnt != MW'(MISS_LIMIT)) miss_cnt <= miss_cnt + MW'(1);
      if (miss_fire)                        fail_q <= 1'b1;
      else if (ctrl_wr && !reg_wdata[5])    fail_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == ADDR_W'(CTRL_ADDR))
      reg_rdata = {osc_en_q, mdet_en_q, fail_q, run_q, alm_en_q, flag_q,
                   set_cnt != '0, cap_cnt != '0};
    for (int i = 0; i < NB; i++) begin
      if (reg_addr == ADDR_W'(HOLD_BASE + i))  reg_rdata = hold_q[i*8 +: 8];
      if (reg_addr == ADDR_W'(ALARM_BASE + i)) reg_rdata = alarm_q[i*8 +: 8];
    end
  end
endmodule

module rtc_ctrl_reg_chk #(
  parameter int ADDR_W    = 4,
  parameter int TW        = 32,
  parameter int CW        = 2,
  parameter int CTRL_ADDR = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [7:0]        reg_wdata,
  input logic              rtc_tick,
  input logic              alarm_pulse,
  input logic              osc_fail,
  input logic              osc_en,
  input logic [TW-1:0]     timer_q,
  input logic [TW-1:0]     hold_q,
  input logic              run_q,
  input logic              alm_en_q,
  input logic              mdet_en_q,
  input logic [CW-1:0]     set_cnt
);
  wire ctrl_wr = reg_wr && reg_addr == ADDR_W'(CTRL_ADDR);

  p_osc_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> osc_en == $past(reg_wdata[7]));

  p_hold_when_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && set_cnt != CW'(1)) |=> $stable(timer_q));

  p_cmd_countdown_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cnt != '0) |=> set_cnt == $past(set_cnt) - CW'(1));

  p_set_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cnt == CW'(1)) |=> timer_q == $past(hold_q));

  p_alarm_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_pulse) |-> $past(rtc_tick && run_q && alm_en_q));

  p_wr_clears_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !alarm_pulse);

  p_fail_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_fail) |-> $past(mdet_en_q && !rtc_tick));
endmodule

bind rtc_ctrl_reg rtc_ctrl_reg_chk #(
  .ADDR_W(ADDR_W), .TW(TW), .CW(CW), .CTRL_ADDR(CTRL_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .rtc_tick(rtc_tick), .alarm_pulse(alarm_pulse),
  .osc_fail(osc_fail), .osc_en(osc_en), .timer_q(timer_q), .hold_q(hold_q),
  .run_q(run_q), .alm_en_q(alm_en_q), .mdet_en_q(mdet_en_q), .set_cnt(set_cnt)
);

// File: tb/rtc_ctrl_reg_tb.sv
module rtc_ctrl_reg_tb_top;
  localparam logic [3:0] CTRL = 4'h4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rtc_tick = 1'b0;
  logic       alarm_pulse, osc_fail, osc_en;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] cfg = 8'h00;

  always #2 clk = ~clk;  // 4 ns period, 250 MHz

  rtc_ctrl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rtc_tick(rtc_tick),
    .alarm_pulse(alarm_pulse), .osc_fail(osc_fail), .osc_en(osc_en)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    peek(a, d);
  endtask

  task automatic tick();
    @(negedge clk);
    rtc_tick = 1'b1;
    @(negedge clk);
    rtc_tick = 1'b0;
  endtask

  task automatic wr32(input logic [3:0] base, input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(base + 4'(i), v[i*8 +: 8]);
  endtask

  task automatic rd32(input logic [3:0] base, output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(base + 4'(i), b);
      v[i*8 +: 8] = b;
    end
  endtask

  task automatic set_timer(input logic [31:0] v);
    wr32(4'h0, v);
    wr(CTRL, cfg | 8'h02);
    repeat (2) @(negedge clk);
  endtask

  task automatic get_timer(output logic [31:0] v);
    wr(CTRL, cfg | 8'h01);
    repeat (2) @(negedge clk);
    rd32(4'h0, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [31:0] v, base, exp;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(CTRL, d);
    check(d == 8'h00, "R1 ctrl", d, 0);
    check({alarm_pulse, osc_fail, osc_en} == 3'b000, "R1 outputs", {alarm_pulse, osc_fail, osc_en}, 0);

    // R2 field readback and map
    wr(CTRL, 8'hD8);
    peek(CTRL, d);
    check(d == 8'hD8, "R2 ctrl readback", d, 8'hD8);
    check(osc_en == 1'b1, "R2 osc_en", osc_en, 1);
    wr(CTRL, 8'h00);
    check(osc_en == 1'b0, "R2 osc_en off", osc_en, 0);
    wr32(4'h0, 32'hA1B2C3D4); wr32(4'h8, 32'h0F1E2D3C);
    rd32(4'h0, v); check(v == 32'hA1B2C3D4, "R2 hold map", v, 32'hA1B2C3D4);
    rd32(4'h8, v); check(v == 32'h0F1E2D3C, "R2 alarm map", v, 32'h0F1E2D3C);

    // R11 unmapped
    rd(4'h5, d); check(d == 8'h00, "R11 addr 5", d, 0);
    rd(4'hF, d); check(d == 8'h00, "R11 addr F", d, 0);

    // R3/R4/R5 sweep: set base, run n ticks, capture
    for (int n = 0; n < 24; n++) begin
      base = n[0] ? 32'hFFFF_FFF4 : 32'(n) * 32'h0101_0101;
      cfg = 8'h10;
      wr(CTRL, cfg);
      set_timer(base);
      for (int k = 0; k < n; k++) tick();
      get_timer(v);
      exp = base + 32'(n);
      check(v == exp, "R3 run count", v, exp);
    end

    // R3 stopped
    cfg = 8'h00; wr(CTRL, cfg);
    set_timer(32'h0000_1234);
    repeat (5) tick();
    get_timer(v);
    check(v == 32'h1234, "R3 stopped hold", v, 32'h1234);

    // R4 bit timing and tick collision
    cfg = 8'h10; wr(CTRL, cfg);
    wr32(4'h0, 32'd500);
    wr(CTRL, cfg | 8'h02);
    peek(CTRL, d); check(d[1] == 1'b1, "R4 busy cycle1", d[1], 1);
    @(negedge clk); rtc_tick = 1'b1;
    peek(CTRL, d); check(d[1] == 1'b1, "R4 busy cycle2", d[1], 1);
    @(negedge clk); rtc_tick = 1'b0;
    peek(CTRL, d); check(d[1] == 1'b0, "R4 self clear", d[1], 0);
    get_timer(v);
    check(v == 32'd500, "R4 tick discarded", v, 500);

    // R5 bit timing and tick collision
    set_timer(32'd100);
    wr(CTRL, cfg | 8'h01);
    peek(CTRL, d); check(d[0] == 1'b1, "R5 busy cycle1", d[0], 1);
    @(negedge clk); rtc_tick = 1'b1;
    peek(CTRL, d); check(d[0] == 1'b1, "R5 busy cycle2", d[0], 1);
    @(negedge clk); rtc_tick = 1'b0;
    peek(CTRL, d); check(d[0] == 1'b0, "R5 self clear", d[0], 0);
    rd32(4'h0, v);
    check(v == 32'd100, "R5 pre-tick value", v, 100);
    get_timer(v);
    check(v == 32'd101, "R5 tick kept", v, 101);

    // R6/R7 alarm sweep
    for (int ar = 0; ar < 2; ar++) begin
      for (int a = 1; a < 5; a++) begin
        cfg = 8'h10; wr(CTRL, cfg);
        set_timer(32'd0);
        wr32(4'h8, 32'(a));
        cfg = 8'h18 | (ar != 0 ? 8'h04 : 8'h00);
        wr(CTRL, cfg);
        peek(CTRL, d);
        check(d == 8'h18, "R7 bit2 reads flag", d, 8'h18);
        for (int k = 0; k < a; k++) tick();
        check(alarm_pulse == 1'b0, "R6 no early alarm", alarm_pulse, 0);
        tick();
        check(alarm_pulse == 1'b1, "R6 alarm raised", alarm_pulse, 1);
        repeat (5) @(negedge clk);
        peek(CTRL, d);
        check(d[2] == 1'b1 && alarm_pulse, "R6 flag held", d[2], 1);
        tick();
        check(alarm_pulse == 1'b0, "R6 cleared by tick", alarm_pulse, 0);
        get_timer(v);
        exp = ar != 0 ? 32'd1 : 32'(a + 2);
        check(v == exp, "R7 auto reset", v, exp);
      end
    end

    // R8 control write clears flag, and wins over same-cycle hit
    cfg = 8'h18; wr(CTRL, cfg);
    set_timer(32'd7); wr32(4'h8, 32'd7);
    tick();
    check(alarm_pulse == 1'b1, "R8 setup", alarm_pulse, 1);
    wr(CTRL, cfg);
    check(alarm_pulse == 1'b0, "R8 write clears", alarm_pulse, 0);
    set_timer(32'd7);
    @(negedge clk);
    rtc_tick = 1'b1; reg_addr = CTRL; reg_wdata = cfg; reg_wr = 1'b1;
    @(negedge clk);
    rtc_tick = 1'b0; reg_wr = 1'b0;
    check(alarm_pulse == 1'b0, "R8 write beats hit", alarm_pulse, 0);

    // R9 missing tick detector
    cfg = 8'hC0; wr(CTRL, cfg);
    repeat (1000) @(negedge clk);
    tick();
    repeat (1000) @(negedge clk);
    check(osc_fail == 1'b0, "R9 ticks restart", osc_fail, 0);
    tick();
    repeat (1023) @(negedge clk);
    check(osc_fail == 1'b0, "R9 1023 idle", osc_fail, 0);
    @(negedge clk);
    check(osc_fail == 1'b1, "R9 1024 idle", osc_fail, 1);
    peek(CTRL, d);
    check(d[5] == 1'b1, "R9 bit5 reads", d[5], 1);

    // R10 clearing
    wr(CTRL, cfg | 8'h20);
    check(osc_fail == 1'b1, "R10 write one keeps", osc_fail, 1);
    wr(CTRL, cfg);
    check(osc_fail == 1'b0, "R10 write zero clears", osc_fail, 0);
    cfg = 8'h00; wr(CTRL, cfg);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule